// File: doc/BRIEF.md
# ATM GFC Serial Extractor

This block takes the four-bit flow-control nibble from the header of each received ATM cell and presents it on a single output wire, one bit per byte-clock cycle. The cell processor pulses a strobe in the cycle when a cell enters the receive buffer, and places the header nibble alongside it. A fixed number of cycles later, six by default, the block raises a one-cycle start marker and shifts the nibble out, most significant bit first.

A delineation-lost flag from the cell processor overrides everything. While it is high, both outputs are held low in the same cycle. Any pending or running sequence is cancelled, and strobes are not accepted. If a new strobe arrives while an earlier nibble is still waiting or shifting, the earlier one is dropped and timing restarts from the new strobe.

Top module: `gfc_serial_extract`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `gfc_ser_o` and `gfc_start_o` are both 0.
- R2: A strobe accepted in cycle n makes `gfc_start_o` high in cycle n+6 (START_DELAY), provided no later strobe and no loss of delineation intervenes.
- R3: `gfc_start_o` is high for exactly one cycle per accepted strobe.
- R4: The nibble sampled with the strobe appears on `gfc_ser_o` over four consecutive cycles, bit 3 first. Bit 3 is in the marker cycle n+6 and bit 0 is in cycle n+9.
- R5: Outside the four shift cycles of the current sequence, `gfc_ser_o` is 0.
- R6: A strobe accepted while an earlier sequence is still waiting or shifting cancels the earlier one from the next cycle on. The new nibble is then emitted relative to the new strobe.
- R7: In any cycle where `delin_lost_i` is 1, both `gfc_ser_o` and `gfc_start_o` are 0.
- R8: `delin_lost_i` high in any cycle cancels the pending or running sequence. Nothing more of it appears after the flag drops.
- R9: A strobe in a cycle where `delin_lost_i` is 1 is ignored and produces no marker and no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_wr_i | input | 1 | One-cycle strobe: a cell was written to the receive buffer |
| gfc_nib_i | input | 4 | Flow-control nibble of that cell's header, valid with the strobe |
| delin_lost_i | input | 1 | Cell delineation lost, active high |
| gfc_ser_o | output | 1 | Serial flow-control bit, MSB first |
| gfc_start_o | output | 1 | One-cycle marker on the cycle carrying the first bit |

## Verification
Two events can fall in the same cycle: a new strobe and an older sequence's marker or data bit. A strobe can also coincide with the delineation-lost flag. The bench provokes the first case by placing a second strobe exactly in the marker cycle of the first, and again in the middle of its shift. It provokes the second case by raising the loss flag in the strobe's own cycle. For each case, an independent per-cycle model derived from the requirements gives the expected outputs. The checks require that the older bit still shows in the colliding cycle and vanishes afterwards, and that a strobe coinciding with loss leaves no trace at all.

// File: rtl/gfc_ser_pkg.sv
package gfc_ser_pkg;

    localparam int GFC_BITS    = 4;
    localparam int START_DELAY = 6;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

    // One cycle of shifter output
    typedef struct packed {
        logic busy;
        logic first;
        logic data;
    } gfc_tap_t;

    // Gate a tap with the loss flag
    function automatic gfc_tap_t gate_tap(input gfc_tap_t t, input logic lost);
        gfc_tap_t r;
        r.busy  = t.busy & ~lost;
        r.first = t.busy & t.first & ~lost;
        r.data  = t.busy & t.data & ~lost;
        return r;
    endfunction

endpackage

// File: rtl/gfc_delay_timer.sv
module gfc_delay_timer
    import gfc_ser_pkg::*;
#(
    parameter int DELAY = START_DELAY   // must be at least 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic abort_i,
    output logic expire_o
);

    localparam int CW       = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam int LOAD_VAL = DELAY - 2;

    tmr_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // Expire in cycle n+DELAY-1, so the shifter shows its first bit in n+DELAY
    assign expire_o = (state_q == TMR_COUNT) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (load_i) begin
            state_q <= TMR_COUNT;
            cnt_q   <= CW'(LOAD_VAL);
        end else if (expire_o) begin
            state_q <= TMR_IDLE;
        end else if (state_q == TMR_COUNT) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/gfc_shift_out.sv
module gfc_shift_out
    import gfc_ser_pkg::*;
#(
    parameter int W = GFC_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         start_i,
    input  logic [W-1:0] nib_i,
    output gfc_tap_t     tap_o
);

    localparam int LW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (start_i) begin
            sh_q   <= nib_i;
            left_q <= LW'(W);
        end else if (left_q != '0) begin
            sh_q   <= {sh_q[W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign tap_o.busy  = (left_q != '0);
    assign tap_o.first = (left_q == LW'(W));
    assign tap_o.data  = sh_q[W-1];

endmodule

// File: rtl/gfc_serial_extract.sv
module gfc_serial_extract
    import gfc_ser_pkg::*;
#(
    parameter int W           = GFC_BITS,
    parameter int START_DELAY = gfc_ser_pkg::START_DELAY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cell_wr_i,
    input  logic [W-1:0] gfc_nib_i,
    input  logic         delin_lost_i,
    output logic         gfc_ser_o,
    output logic         gfc_start_o
);

    logic         accept;
    logic         expire;
    logic [W-1:0] nib_q;
    gfc_tap_t     raw_tap;
    gfc_tap_t     out_tap;

    // Strobes are refused while delineation is lost
    assign accept = cell_wr_i & ~delin_lost_i;

    always_ff @(posedge clk) begin
        if (rst)
            nib_q <= '0;
        else if (accept)
            nib_q <= gfc_nib_i;
    end

    gfc_delay_timer #(.DELAY(START_DELAY)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept),
        .abort_i  (delin_lost_i),
        .expire_o (expire)
    );

    // A new strobe or loss flushes any running shift
    gfc_shift_out #(.W(W)) shf_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept | delin_lost_i),
        .start_i (expire),
        .nib_i   (nib_q),
        .tap_o   (raw_tap)
    );

    assign out_tap     = gate_tap(raw_tap, delin_lost_i);
    assign gfc_ser_o   = out_tap.data;
    assign gfc_start_o = out_tap.first;

endmodule

// File: rtl/gfc_serial_extract_chk.sv
module gfc_serial_extract_chk #(
    parameter int W           = 4,
    parameter int START_DELAY = 6
) (
    input logic clk,
    input logic rst,
    input logic cell_wr_i,
    input logic delin_lost_i,
    input logic gfc_ser_o,
    input logic gfc_start_o
);

    localparam int LIM = START_DELAY + W + 1;
    localparam int SW  = $clog2(LIM + 1) + 1;

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)
            since_q <= SW'(LIM);
        else if (cell_wr_i)
            since_q <= SW'(1);
        else if (since_q < SW'(LIM))
            since_q <= since_q + 1'b1;
    end

    // R2
    start_delay_chk: assert property (@(posedge clk) disable iff (rst)
        gfc_start_o |-> (since_q == SW'(START_DELAY)));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        gfc_start_o |=> !gfc_start_o);

    // R5
    ser_window_chk: assert property (@(posedge clk) disable iff (rst)
        gfc_ser_o |-> (since_q >= SW'(START_DELAY)) && (since_q < SW'(START_DELAY + W)));

    // R7
    lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        delin_lost_i |-> (!gfc_ser_o && !gfc_start_o));

endmodule

bind gfc_serial_extract gfc_serial_extract_chk #(.W(W), .START_DELAY(START_DELAY)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cell_wr_i    (cell_wr_i),
    .delin_lost_i (delin_lost_i),
    .gfc_ser_o    (gfc_ser_o),
    .gfc_start_o  (gfc_start_o)
);

// File: tb/gfc_serial_extract_tb.sv
module gfc_serial_extract_tb_top;

    localparam int NC  = 24;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cell_wr_i = 1'b0;
    logic [3:0] gfc_nib_i = '0;
    logic       delin_lost_i = 1'b0;
    logic       gfc_ser_o;
    logic       gfc_start_o;

    int checks = 0;
    int fails  = 0;

    logic       s_wr   [NC];
    logic [3:0] s_nib  [NC];
    logic       s_lost [NC];

    always #5 clk = ~clk;

    gfc_serial_extract dut_i (
        .clk          (clk),
        .rst          (rst),
        .cell_wr_i    (cell_wr_i),
        .gfc_nib_i    (gfc_nib_i),
        .delin_lost_i (delin_lost_i),
        .gfc_ser_o    (gfc_ser_o),
        .gfc_start_o  (gfc_start_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int c = 0; c < NC; c++) begin
            s_wr[c] = 1'b0; s_nib[c] = 4'h0; s_lost[c] = 1'b0;
        end
    endtask

    // Drive the stimulus arrays and compare with a per-cycle requirement model
    task automatic run(input string tag);
        int         st_at;
        logic [3:0] nv;
        logic       e_ser, e_st;
        st_at = -100;
        nv    = 4'h0;
        for (int c = 0; c < NC; c++) begin
            @(negedge clk);
            cell_wr_i    = s_wr[c];
            gfc_nib_i    = s_nib[c];
            delin_lost_i = s_lost[c];
            #1;
            e_ser = 1'b0; e_st = 1'b0;
            if (!s_lost[c] && c >= st_at && c < st_at + 4) begin
                e_ser = nv[3 - (c - st_at)];
                e_st  = (c == st_at);
            end
            check(tag, $sformatf("start c%0d", c), gfc_start_o, e_st);
            check(tag, $sformatf("ser c%0d", c), gfc_ser_o, e_ser);
            if (s_lost[c])
                st_at = -100;
            else if (s_wr[c]) begin
                st_at = c + DLY;
                nv    = s_nib[c];
            end
        end
        @(negedge clk);
        cell_wr_i = 1'b0; delin_lost_i = 1'b0; gfc_nib_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "ser in reset", gfc_ser_o, 1'b0);
        check("R1", "start in reset", gfc_start_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "ser after reset", gfc_ser_o, 1'b0);
        check("R1", "start after reset", gfc_start_o, 1'b0);
    endtask

    task automatic t_basic(input logic [3:0] n);
        clear_stim();
        s_wr[2] = 1'b1; s_nib[2] = n;
        run("R2 R3 R4 R5");
    endtask

    task automatic t_restart_wait();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'h9;
        s_wr[4] = 1'b1; s_nib[4] = 4'h6;
        run("R6 wait");
    endtask

    task automatic t_restart_shift();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'hF;
        s_wr[8] = 1'b1; s_nib[8] = 4'h5;
        run("R6 shift");
    endtask

    task automatic t_restart_marker();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'hC;
        s_wr[7] = 1'b1; s_nib[7] = 4'h3;
        run("R6 marker");
    endtask

    task automatic t_lost_mid();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'hF;
        s_lost[8] = 1'b1;
        run("R7 R8 mid");
    endtask

    task automatic t_lost_at_marker();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'hB;
        s_lost[7] = 1'b1;
        run("R7 R8 marker");
    endtask

    task automatic t_lost_wait();
        clear_stim();
        s_wr[1] = 1'b1; s_nib[1] = 4'hF;
        s_lost[3] = 1'b1; s_lost[4] = 1'b1;
        run("R8 wait");
    endtask

    task automatic t_strobe_lost();
        clear_stim();
        s_lost[2] = 1'b1;
        s_wr[2] = 1'b1; s_nib[2] = 4'hF;
        run("R9");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic(4'hA);
        t_basic(4'h1);
        t_basic(4'hF);
        t_basic(4'h6);
        t_basic(4'h0);
        t_restart_wait();
        t_restart_shift();
        t_restart_marker();
        t_lost_mid();
        t_lost_at_marker();
        t_lost_wait();
        t_strobe_lost();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule